// File: doc/BRIEF.md
# Bounded Multi-Word NVM Read Engine

This block fetches a run of consecutive 16-bit words from a word-addressed non-volatile memory for a host. The host presents a start offset and a word count together with a one-cycle `go` pulse. Before touching the memory, the engine checks the request against the configured memory size. A request that does not fit is refused with an error and causes no memory access.

An accepted request becomes a series of single-word transactions with a memory-side responder. For each word the engine writes a command word that carries the address and a start flag. It then samples the responder's status word at a fixed interval until the status reports completion. The 16-bit result goes out on a one-cycle valid stream. The number of samples per word is bounded. If one word never completes, the burst stops at that word with an error, and the words already delivered stay valid.

The sampling interval is a clock-cycle count computed from the clock frequency in MHz and the interval in microseconds. The real spacing between samples therefore stays the same at any clock rate.

Top module: `nvm_burst_reader`

## Requirements
- R1: A request whose offset is greater than or equal to MEM_WORDS is refused. One cycle after `go`, `done` and `err` are both high for one cycle. `cmd_wr` never rises, `word_valid` never rises, and `busy` stays low.
- R2: A request whose count is zero, or whose count is larger than MEM_WORDS minus the offset, is refused in the same way as R1. A request that ends exactly at the last word (offset + count = MEM_WORDS) is accepted.
- R3: For an accepted request, word i is fetched from address offset+i. Addresses are issued in increasing order, with exactly one `cmd_wr` pulse per word.
- R4: `cmd_word` carries the address in bits 15:2, a start flag of 1 in bit 0, and 0 in bit 1. The engine treats bit 1 of `stat_word` as the completion flag and takes the result from bits 31:16. Each result is presented on `word_data` with `word_valid` high for exactly one cycle.
- R5: The status word is sampled once every POLL_CYCLES+1 cycles, with POLL_CYCLES = CLK_MHZ*POLL_US, and at most MAX_POLLS times per word. The k-th sample falls k*(POLL_CYCLES+1) clock edges after the `cmd_wr` edge. A word that completes before the last sample is delivered. A word that does not gives `done` with `err` exactly MAX_POLLS*(POLL_CYCLES+1)+1 cycles after its `cmd_wr` cycle.
- R6: A word that times out ends the burst at once. Earlier words remain delivered, no later address is issued, and `done` with `err` is raised for one cycle.
- R7: `busy` rises the cycle after an accepted `go` and falls in the cycle `done` is high. A `go` that arrives while `busy` is high is dropped: it is neither served nor queued.
- R8: A burst that completes raises `done` for one cycle with `err` low. This is the same cycle in which the last word is valid.
- R9: After reset, `busy`, `done`, `err`, `word_valid` and `cmd_wr` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| go | input | 1 | One-cycle request strobe |
| offset | input | 14 | First word address of the burst |
| count | input | 15 | Number of words to fetch |
| busy | output | 1 | High while an accepted burst runs |
| done | output | 1 | One-cycle end-of-request strobe |
| err | output | 1 | Valid with done: request refused or a word timed out |
| word_valid | output | 1 | One-cycle strobe for word_data |
| word_data | output | 16 | Fetched word |
| cmd_wr | output | 1 | Command write strobe to the responder |
| cmd_word | output | 32 | Command: address 15:2, start flag bit 0 |
| stat_word | input | 32 | Responder status: completion bit 1, data 31:16 |

## Verification
The hardest situation to reach from the ports is the exact edge of the poll budget. A word must complete one cycle before the final sample in one run and one cycle too late in another, and the timeout must also strike in the middle of a burst. The bench builds the engine with a small poll interval and a small poll budget. Its responder model has a programmable latency and one address that never completes. Setting the latency to the last accepted value and then one cycle higher tests the boundary. Pointing the stuck address into the middle of a burst shows the partial delivery and the halt. The same model also lets a second `go` be injected while a slow burst is still running.

// File: rtl/nvmrd_pkg.sv
package nvmrd_pkg;

    localparam int WORD_W    = 16;
    localparam int REG_W     = 32;
    localparam int FADDR_W   = 14;
    localparam int START_BIT = 0;
    localparam int DONE_BIT  = 1;
    localparam int ADDR_LSB  = 2;
    localparam int DATA_LSB  = 16;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ISSUE,
        ST_WAIT,
        ST_POLL
    } rd_state_e;

    typedef struct packed {
        logic [WORD_W-1:0]  data;
        logic [FADDR_W-1:0] addr;
        logic               done;
        logic               start;
    } nvm_reg_t;

    function automatic logic [REG_W-1:0] make_cmd(input logic [FADDR_W-1:0] a);
        nvm_reg_t c;
        c.data  = '0;
        c.addr  = a;
        c.done  = 1'b0;
        c.start = 1'b1;
        return c;
    endfunction

endpackage

// File: rtl/nvmrd_range_chk.sv
module nvmrd_range_chk #(
    parameter int MEM_WORDS = 1024,
    parameter int ADDR_W    = 14,
    parameter int CNT_W     = 15
) (
    input  logic [ADDR_W-1:0] offset,
    input  logic [CNT_W-1:0]  count,
    output logic              fits
);
    localparam logic [31:0] MEM_U = 32'(MEM_WORDS);

    logic [31:0] off_u;
    logic [31:0] cnt_u;

    always_comb begin
        off_u = 32'(offset);
        cnt_u = 32'(count);
        fits  = (off_u < MEM_U) && (cnt_u != 32'd0) && (cnt_u <= (MEM_U - off_u));
    end
endmodule

// File: rtl/nvmrd_poll_timer.sv
module nvmrd_poll_timer #(
    parameter int POLL_CYCLES = 1250,
    parameter int MAX_POLLS   = 100000
) (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic wait_en,
    input  logic missed,
    output logic due,
    output logic spent
);
    localparam int IW = $clog2(POLL_CYCLES + 1);
    localparam int PW = $clog2(MAX_POLLS + 1);

    logic [IW-1:0] icnt;
    logic [PW-1:0] pcnt;

    assign due   = (icnt == IW'(POLL_CYCLES - 1));
    assign spent = (pcnt == PW'(MAX_POLLS - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            icnt <= '0;
            pcnt <= '0;
        end else begin
            if (arm || missed)
                icnt <= '0;
            else if (wait_en && !due)
                icnt <= icnt + IW'(1);

            if (arm)
                pcnt <= '0;
            else if (missed && !spent)
                pcnt <= pcnt + PW'(1);
        end
    end
endmodule

// File: rtl/nvm_burst_reader.sv
module nvm_burst_reader
    import nvmrd_pkg::*;
#(
    parameter int MEM_WORDS = 1024,
    parameter int CLK_MHZ   = 250,
    parameter int POLL_US   = 5,
    parameter int MAX_POLLS = 100000
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 go,
    input  logic [FADDR_W-1:0]   offset,
    input  logic [FADDR_W:0]     count,
    output logic                 busy,
    output logic                 done,
    output logic                 err,
    output logic                 word_valid,
    output logic [WORD_W-1:0]    word_data,
    output logic                 cmd_wr,
    output logic [REG_W-1:0]     cmd_word,
    input  logic [REG_W-1:0]     stat_word
);
    localparam int POLL_CYCLES = CLK_MHZ * POLL_US;
    localparam int CNT_W       = FADDR_W + 1;

    rd_state_e          state;
    logic [FADDR_W-1:0] cur_addr;
    logic [CNT_W-1:0]   left;
    logic               busy_r, done_r, err_r, wv_r;
    logic [WORD_W-1:0]  wd_r;

    logic               range_ok;
    logic               poll_due, polls_spent;
    logic               resp_done;
    logic [WORD_W-1:0]  resp_data;
    logic               stat_unused_bits;

    assign resp_done        = stat_word[DONE_BIT];
    assign resp_data        = stat_word[DATA_LSB +: WORD_W];
    assign stat_unused_bits = ^{stat_word[DATA_LSB-1:ADDR_LSB], stat_word[START_BIT]};

    nvmrd_range_chk #(
        .MEM_WORDS (MEM_WORDS),
        .ADDR_W    (FADDR_W),
        .CNT_W     (CNT_W)
    ) u_range (
        .offset (offset),
        .count  (count),
        .fits   (range_ok)
    );

    nvmrd_poll_timer #(
        .POLL_CYCLES (POLL_CYCLES),
        .MAX_POLLS   (MAX_POLLS)
    ) u_timer (
        .clk     (clk),
        .rst     (rst),
        .arm     (state == ST_ISSUE),
        .wait_en (state == ST_WAIT),
        .missed  ((state == ST_POLL) && !resp_done),
        .due     (poll_due),
        .spent   (polls_spent)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            cur_addr <= '0;
            left     <= '0;
            busy_r   <= 1'b0;
            done_r   <= 1'b0;
            err_r    <= 1'b0;
            wv_r     <= 1'b0;
            wd_r     <= '0;
        end else begin
            done_r <= 1'b0;
            err_r  <= 1'b0;
            wv_r   <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (go) begin
                        if (range_ok) begin
                            busy_r   <= 1'b1;
                            cur_addr <= offset;
                            left     <= count;
                            state    <= ST_ISSUE;
                        end else begin
                            done_r <= 1'b1;
                            err_r  <= 1'b1;
                        end
                    end
                end
                ST_ISSUE: state <= ST_WAIT;
                ST_WAIT: begin
                    if (poll_due)
                        state <= ST_POLL;
                end
                ST_POLL: begin
                    if (resp_done) begin
                        wv_r <= 1'b1;
                        wd_r <= resp_data;
                        if (left == CNT_W'(1)) begin
                            done_r <= 1'b1;
                            busy_r <= 1'b0;
                            state  <= ST_IDLE;
                        end else begin
                            left     <= left - CNT_W'(1);
                            cur_addr <= cur_addr + FADDR_W'(1);
                            state    <= ST_ISSUE;
                        end
                    end else if (polls_spent) begin
                        done_r <= 1'b1;
                        err_r  <= 1'b1;
                        busy_r <= 1'b0;
                        state  <= ST_IDLE;
                    end else begin
                        state <= ST_WAIT;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    assign busy       = busy_r;
    assign done       = done_r;
    assign err        = err_r;
    assign word_valid = wv_r;
    assign word_data  = wd_r;
    assign cmd_wr     = (state == ST_ISSUE);
    assign cmd_word   = make_cmd(cur_addr);

endmodule

// File: rtl/nvmrd_checker.sv
module nvmrd_checker (
    input logic        clk,
    input logic        rst,
    input logic        go,
    input logic        busy,
    input logic        done,
    input logic        err,
    input logic        word_valid,
    input logic [15:0] word_data,
    input logic        cmd_wr,
    input logic [31:0] cmd_word,
    input logic [31:0] stat_word
);
    logic        have_prev;
    logic [13:0] prev_addr;

    always_ff @(posedge clk) begin
        if (rst || !busy) begin
            have_prev <= 1'b0;
            prev_addr <= '0;
        end else if (cmd_wr) begin
            have_prev <= 1'b1;
            prev_addr <= cmd_word[15:2];
        end
    end

    a_r1_idle_no_access: assert property (@(posedge clk) disable iff (rst)
        !busy |-> !cmd_wr);

    a_r3_addr_step: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && have_prev) |-> (cmd_word[15:2] == 14'(prev_addr + 14'd1)));

    a_r4_word_from_status: assert property (@(posedge clk) disable iff (rst)
        word_valid |-> ($past(stat_word[1]) && (word_data == $past(stat_word[31:16]))));

    a_r6_no_word_on_error: assert property (@(posedge clk) disable iff (rst)
        (done && err) |-> !word_valid);

    a_r7_done_drops_busy: assert property (@(posedge clk) disable iff (rst)
        done |-> !busy);

    a_r7_busy_until_done: assert property (@(posedge clk) disable iff (rst)
        busy |=> (busy || done));

    a_r8_done_single: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    logic unused_go;
    assign unused_go = go;
endmodule

bind nvm_burst_reader nvmrd_checker u_chk (.*);

// File: tb/sim_nvm_burst_reader.sv
module sim_nvm_burst_reader;
    localparam int MEMW = 32;
    localparam int MHZ  = 2;
    localparam int US   = 5;
    localparam int MAXP = 6;
    localparam int PC   = MHZ * US;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        go = 1'b0;
    logic [13:0] offset = '0;
    logic [14:0] count = '0;
    logic        busy, done, err, word_valid, cmd_wr;
    logic [15:0] word_data;
    logic [31:0] cmd_word, stat_word;

    always #2 clk = ~clk;

    nvm_burst_reader #(
        .MEM_WORDS (MEMW), .CLK_MHZ (MHZ), .POLL_US (US), .MAX_POLLS (MAXP)
    ) u0 (
        .clk (clk), .rst (rst), .go (go), .offset (offset), .count (count),
        .busy (busy), .done (done), .err (err), .word_valid (word_valid),
        .word_data (word_data), .cmd_wr (cmd_wr), .cmd_word (cmd_word),
        .stat_word (stat_word)
    );

    function automatic logic [15:0] mval(input int a);
        return 16'(32'hA5C3 ^ (a * 313));
    endfunction

    int          lat = 0;
    logic [13:0] hang_addr = 14'h3FFF;
    logic        pend;
    logic [13:0] paddr;
    int          rcnt;
    logic        rdone;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend <= 1'b0; paddr <= '0; rcnt <= 0;
        end else if (cmd_wr) begin
            pend <= 1'b1; paddr <= cmd_word[15:2]; rcnt <= 0;
        end else if (pend && rcnt < lat) begin
            rcnt <= rcnt + 1;
        end
    end
    assign rdone     = pend && (rcnt >= lat) && (paddr != hang_addr);
    assign stat_word = {(rdone ? mval(int'(paddr)) : 16'h0000), paddr, rdone, 1'b0};

    int          cyc = 0;
    int          n_acc, n_w, n_done, busy_cyc, bad_start, cmd_cyc, done_cyc;
    logic        last_err;
    logic [13:0] acc_addr [64];
    logic [15:0] words [64];

    always @(negedge clk) begin
        cyc <= cyc + 1;
        if (!rst) begin
            if (cmd_wr) begin
                if (n_acc < 64) acc_addr[n_acc] = cmd_word[15:2];
                if (cmd_word[1:0] != 2'b01) bad_start = bad_start + 1;
                n_acc = n_acc + 1;
                cmd_cyc = cyc;
            end
            if (word_valid) begin
                if (n_w < 64) words[n_w] = word_data;
                n_w = n_w + 1;
            end
            if (done) begin
                n_done = n_done + 1;
                last_err = err;
                done_cyc = cyc;
            end
            if (busy) busy_cyc = busy_cyc + 1;
        end
    end

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic clear_logs();
        n_acc = 0; n_w = 0; n_done = 0; busy_cyc = 0; bad_start = 0;
        last_err = 1'b0; cmd_cyc = 0; done_cyc = 0;
    endtask

    task automatic pulse_go(input int off, input int cnt);
        @(negedge clk);
        go = 1'b1; offset = 14'(off); count = 15'(cnt);
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_done();
        int w = 0;
        while (n_done == 0 && w < 5000) begin
            @(negedge clk);
            w++;
        end
        repeat (20) @(negedge clk);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(!busy && !done && !err && !word_valid && !cmd_wr, "R9", "outputs after reset",
              int'({busy, done, err, word_valid, cmd_wr}), 0);
    endtask

    task automatic t_reject(input int off, input int cnt, input string req);
        clear_logs();
        pulse_go(off, cnt);
        repeat (6) @(negedge clk);
        check(n_done == 1 && last_err, req, "refusal done+err", n_done, 1);
        check(n_acc == 0 && n_w == 0, req, "no access on refusal", n_acc + n_w, 0);
        check(busy_cyc == 0, req, "busy stays low on refusal", busy_cyc, 0);
    endtask

    task automatic t_burst(input int off, input int cnt, input int l, input string req);
        int bad = 0;
        clear_logs();
        lat = l;
        pulse_go(off, cnt);
        wait_done();
        check(n_done == 1 && !last_err, req, "done without err", n_done, 1);
        check(n_acc == cnt && n_w == cnt, "R3", "one access and one word per word", n_acc, cnt);
        for (int i = 0; i < cnt && i < 64; i++) begin
            if (acc_addr[i] != 14'(off + i)) bad++;
            if (words[i] != mval(off + i)) bad++;
        end
        check(bad == 0, "R3", "addresses and data in order", bad, 0);
        check(bad_start == 0, "R4", "command start/done bits", bad_start, 0);
        check(done_cyc == cmd_cyc + PC + 2 || cnt == 0, "R8", "done with last word",
              done_cyc - cmd_cyc, PC + 2 + 0);
    endtask

    task automatic t_latency_edge();
        clear_logs();
        lat = MAXP * (PC + 1) - 1;
        pulse_go(7, 1);
        wait_done();
        check(n_done == 1 && !last_err && n_w == 1 && words[0] == mval(7), "R5",
              "word done just before last poll", n_w, 1);
        clear_logs();
        lat = MAXP * (PC + 1);
        pulse_go(7, 1);
        wait_done();
        check(n_done == 1 && last_err && n_w == 0, "R5", "word done just after last poll",
              int'(last_err), 1);
        check(done_cyc - cmd_cyc == MAXP * (PC + 1) + 1, "R5", "timeout spacing",
              done_cyc - cmd_cyc, MAXP * (PC + 1) + 1);
    endtask

    task automatic t_mid_timeout();
        clear_logs();
        lat = 3;
        hang_addr = 14'd12;
        pulse_go(10, 5);
        wait_done();
        hang_addr = 14'h3FFF;
        check(n_done == 1 && last_err, "R6", "abort reports err", int'(last_err), 1);
        check(n_w == 2 && words[0] == mval(10) && words[1] == mval(11), "R6",
              "earlier words kept", n_w, 2);
        check(n_acc == 3, "R6", "no later address issued", n_acc, 3);
    endtask

    task automatic t_go_while_busy();
        clear_logs();
        lat = 20;
        pulse_go(4, 3);
        repeat (15) @(negedge clk);
        go = 1'b1; offset = 14'd20; count = 15'd1;
        @(negedge clk);
        go = 1'b0;
        wait_done();
        repeat (40) @(negedge clk);
        check(n_done == 1 && !last_err, "R7", "single completion", n_done, 1);
        check(n_acc == 3 && acc_addr[2] == 14'd6, "R7", "second go dropped", n_acc, 3);
        check(busy_cyc > 0, "R7", "busy during burst", busy_cyc, 1);
    endtask

    initial begin
        clear_logs();
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_reject(MEMW, 1, "R1");
        t_reject(MEMW + 5, 2, "R1");
        t_reject(3, 0, "R2");
        t_reject(MEMW - 2, 3, "R2");
        t_burst(MEMW - 2, 2, 0, "R2");
        t_burst(0, 1, 0, "R8");
        t_burst(5, 4, 4, "R8");
        t_burst(0, MEMW, 1, "R3");
        t_latency_edge();
        t_mid_timeout();
        t_go_while_busy();
        if (!finished) begin
            finished = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule